// File: doc/BRIEF.md
# Bit-Field Insert with XNOR Merge

This block is the execution slice of a 16-bit register-to-register processor that handles one bit-field operation. A control word, held in a second source register, gives a 4-bit width code and a 4-bit offset. Together they select a contiguous field in the destination register. The low bits of the first source register are shifted up to that offset. Each one is then merged with the destination bit it lands on using XNOR, meaning the inverse of their exclusive-or. The outcome is written back to the destination. Every destination bit outside the field keeps its value. A field that would reach past the top bit is cut off there.

The unit contains its own small register file and a four-bit condition flag register. It reads three registers, computes the result and updates both the register and the flags on a single rising edge, qualified by an operation strobe. The surrounding core fills registers through a load port and may overwrite the flags directly. A combinational peek port lets it read any register back. Register 0 is hardwired to zero. Using it as the first source therefore inverts the selected destination bits.

Top module: `bfx_unit`

## Requirements
- R1: With control word K = contents of `op_rs2`, width code w = K[7:4] and offset o = K[3:0]. Destination bits o..o+w become ~(S[k-o] ^ D[k]), where S is the first source and D the old destination.
- R2: Destination bits outside the field o..o+w keep their previous values.
- R3: When o+w > 15, field positions above bit 15 are discarded, and bits o..15 are still merged.
- R4: After an operation, `flag_n` equals bit 15 of the result.
- R5: After an operation, `flag_z` is 1 exactly when the full 16-bit result is zero.
- R6: After an operation, `flag_v` is 0 and `flag_c` keeps its previous value.
- R7: Register 0 always reads as zero. Loads or operations aimed at it change nothing in the register file, but an operation with destination 0 still updates the flags from a zero destination.
- R8: Registers and flags change only on a rising edge where `op_valid`, `ld_valid` or `flag_wr` is high.
- R9: A synchronous active-low reset clears every register and all four flags.
- R10: `ld_valid` writes `ld_data` to `ld_idx`. `flag_wr` loads `flag_din` as {N,Z,V,C} = bits [3:0]. In a cycle with `op_valid` high, both load requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Perform the operation this cycle |
| op_rd | input | 3 | Destination register index |
| op_rs1 | input | 3 | First source (bits to insert) index |
| op_rs2 | input | 3 | Control word register index |
| ld_valid | input | 1 | Register load request |
| ld_idx | input | 3 | Register index to load |
| ld_data | input | 16 | Data to load |
| flag_wr | input | 1 | Flag load request |
| flag_din | input | 4 | Flag value {N,Z,V,C} |
| peek_idx | input | 3 | Register index to read back |
| peek_data | output | 16 | Contents of register `peek_idx` (combinational) |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Every result of the block lands on the rising edge that samples `op_valid`, `ld_valid` or `flag_wr`. It is visible one edge after the stimulus: on the peek port, which adds no register, and on the flag outputs. The bench drives each request on a falling edge and withdraws it on the next falling edge. It then sets `peek_idx` and samples one nanosecond later, well away from any rising edge. The sweep covers all 256 width/offset pairs under four data patterns, comparing field bits, outside bits and each flag against an arithmetic model.

// File: rtl/bfx_pkg.sv
`timescale 1ns/1ps
// bfx_pkg: types shared by the bit-field XNOR unit.
// Assumes flags travel as {n,z,v,c}, n in the most significant position.
package bfx_pkg;
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } bfx_flags_t;
endpackage

// File: rtl/bfx_regfile.sv
`timescale 1ns/1ps
// bfx_regfile: NREG x DW register file, four combinational read ports and one
// synchronous write port. Entry 0 is never written and always reads zero.
// Assumes NREG is a power of two so every index value addresses an entry.
module bfx_regfile #(
    parameter int  DW    = 16,
    parameter int  NREG  = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    input  logic [IDX_W-1:0] rb_idx,
    input  logic [IDX_W-1:0] rc_idx,
    input  logic [IDX_W-1:0] rp_idx,
    output logic [DW-1:0]    ra_data,
    output logic [DW-1:0]    rb_data,
    output logic [DW-1:0]    rc_data,
    output logic [DW-1:0]    rp_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data
);
    logic [DW-1:0] store [NREG];

    // Purpose: clear on reset, otherwise commit a write to any entry but zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) store[i] <= '0;
        end else if (wr_en && (wr_idx != '0)) begin
            store[wr_idx] <= wr_data;
        end
    end

    // Purpose: asynchronous read ports.
    assign ra_data = store[ra_idx];
    assign rb_data = store[rb_idx];
    assign rc_data = store[rc_idx];
    assign rp_data = store[rp_idx];

    // Register 0 never leaves zero.
    assert_r0_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        store[0] == '0);

    // A write to a nonzero entry lands there on the next edge.
    for (genvar g = 1; g < NREG; g++) begin : g_wr_chk
        assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g)) |=> store[g] == $past(wr_data));
        assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> store[g] == $past(store[g]));
    end
endmodule

// File: rtl/bfx_field_mask.sv
`timescale 1ns/1ps
// bfx_field_mask: decodes the control byte into width code, offset and a DW-bit
// field mask covering bits off..off+wid, clipped at the top bit.
// Assumes DW is a power of two and DW >= 2*FW.
module bfx_field_mask #(
    parameter int  DW = 16,
    localparam int FW = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*FW-1:0] ctl,
    output logic [FW-1:0]   wid,
    output logic [FW-1:0]   off,
    output logic [DW-1:0]   mask
);
    // Purpose: split the control byte, width in the upper half.
    assign wid = ctl[2*FW-1:FW];
    assign off = ctl[FW-1:0];

    // Purpose: one compare pair per bit position; positions past DW-1 simply do not exist.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign mask[i] = (FW'(i) >= off) && ((FW'(i) - off) <= wid);
    end

    int exp_cnt;
    // Purpose: expected field size for the assertion, min(wid+1, DW-off).
    always_comb begin
        exp_cnt = ((int'(wid) + 1) < (DW - int'(off))) ? (int'(wid) + 1) : (DW - int'(off));
    end

    // Field is clipped at the top bit but never empty.
    assert_clip_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask) == exp_cnt);
    assert_field_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mask[off] == 1'b1);
endmodule

// File: rtl/bfx_xnor_merge.sv
`timescale 1ns/1ps
// bfx_xnor_merge: aligns the source to the field offset, XNORs it into the
// destination under the mask and produces the N and Z results.
// Assumes the mask was built for the same offset.
module bfx_xnor_merge #(
    parameter int  DW = 16,
    localparam int FW = $clog2(DW)
) (
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] mask,
    input  logic [FW-1:0] off,
    output logic [DW-1:0] res,
    output logic          res_n,
    output logic          res_z
);
    logic [DW-1:0] aligned;

    // Purpose: move source bit 0 to the field base; bits shifted out are lost.
    assign aligned = src << off;

    // Purpose: keep outside bits, XNOR inside bits.
    assign res = (dst & ~mask) | (~(aligned ^ dst) & mask);

    // Purpose: condition results.
    assign res_n = res[DW-1];
    assign res_z = (res == '0);
endmodule

// File: rtl/bfx_unit.sv
`timescale 1ns/1ps
// bfx_unit: single-cycle bit-field insert with XNOR merge. Reads rd, rs1, rs2,
// writes the merged value back to rd and updates flags on the op_valid edge.
// Register loads and flag loads share the write path and lose to an operation.
module bfx_unit #(
    parameter int  DW    = 16,
    parameter int  NREG  = 8,
    localparam int IDX_W = $clog2(NREG),
    localparam int FW    = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [IDX_W-1:0] op_rd,
    input  logic [IDX_W-1:0] op_rs1,
    input  logic [IDX_W-1:0] op_rs2,
    input  logic             ld_valid,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [DW-1:0]    ld_data,
    input  logic             flag_wr,
    input  logic [3:0]       flag_din,
    input  logic [IDX_W-1:0] peek_idx,
    output logic [DW-1:0]    peek_data,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_v,
    output logic             flag_c
);
    import bfx_pkg::*;

    logic [DW-1:0]    src_val, ctl_val, dst_val, merged;
    logic [DW-1:0]    mask;
    logic [FW-1:0]    wid, off;
    logic             res_n, res_z;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [DW-1:0]    wr_data;
    bfx_flags_t       flags_q;

    bfx_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (op_rs1),
        .rb_idx  (op_rs2),
        .rc_idx  (op_rd),
        .rp_idx  (peek_idx),
        .ra_data (src_val),
        .rb_data (ctl_val),
        .rc_data (dst_val),
        .rp_data (peek_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    bfx_field_mask #(.DW(DW)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl_val[2*FW-1:0]),
        .wid   (wid),
        .off   (off),
        .mask  (mask)
    );

    bfx_xnor_merge #(.DW(DW)) u_merge (
        .src   (src_val),
        .dst   (dst_val),
        .mask  (mask),
        .off   (off),
        .res   (merged),
        .res_n (res_n),
        .res_z (res_z)
    );

    // Purpose: write-port arbitration, operation over load.
    always_comb begin
        if (op_valid) begin
            wr_en   = 1'b1;
            wr_idx  = op_rd;
            wr_data = merged;
        end else begin
            wr_en   = ld_valid;
            wr_idx  = ld_idx;
            wr_data = ld_data;
        end
    end

    // Purpose: flag register; an operation sets N,Z, clears V, holds C.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (op_valid) begin
            flags_q.n <= res_n;
            flags_q.z <= res_z;
            flags_q.v <= 1'b0;
        end else if (flag_wr) begin
            flags_q <= bfx_flags_t'(flag_din);
        end
    end

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_v = flags_q.v;
    assign flag_c = flags_q.c;

    assert_n_bit15_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> flag_n == $past(merged[DW-1]));
    assert_z_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> flag_z == ($past(merged) == '0));
    assert_v_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !flag_v);
    assert_c_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> flag_c == $past(flag_c));
    assert_flags_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !flag_wr) |=> $stable(flags_q));
    assert_outside_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> ((merged & ~mask) == (dst_val & ~mask)));
endmodule

// File: tb/bfx_unit_bench.sv
`timescale 1ns/1ps
module bfx_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, ld_valid = 1'b0, flag_wr = 1'b0;
    logic [2:0]  op_rd = '0, op_rs1 = '0, op_rs2 = '0, ld_idx = '0, peek_idx = '0;
    logic [15:0] ld_data = '0, peek_data;
    logic [3:0]  flag_din = '0;
    logic        flag_n, flag_z, flag_v, flag_c;
    int          total = 0, bad = 0;
    logic [31:0] seed = 32'h1F2E3D4C;

    always #2.5 clk = ~clk;

    bfx_unit u_bfx_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_rd(op_rd),
        .op_rs1(op_rs1), .op_rs2(op_rs2), .ld_valid(ld_valid), .ld_idx(ld_idx),
        .ld_data(ld_data), .flag_wr(flag_wr), .flag_din(flag_din),
        .peek_idx(peek_idx), .peek_data(peek_data), .flag_n(flag_n),
        .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [15:0] fmask(input logic [7:0] k);
        logic [15:0] m = '0;
        for (int b = 0; b < 16; b++)
            if (b >= int'(k[3:0]) && b <= int'(k[3:0]) + int'(k[7:4])) m[b] = 1'b1;
        return m;
    endfunction

    function automatic logic [15:0] model(input logic [15:0] s, input logic [7:0] k, input logic [15:0] d);
        logic [15:0] r = d;
        int o = int'(k[3:0]);
        for (int b = 0; b < 16; b++)
            if (fmask(k)[b]) r[b] = ~(s[b-o] ^ d[b]);
        return r;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [2:0] idx, output logic [15:0] val);
        peek_idx = idx;
        #1;
        val = peek_data;
    endtask

    task automatic load(input logic [2:0] idx, input logic [15:0] val);
        @(negedge clk); ld_valid = 1'b1; ld_idx = idx; ld_data = val;
        @(negedge clk); ld_valid = 1'b0;
    endtask

    task automatic set_flags(input logic [3:0] f);
        @(negedge clk); flag_wr = 1'b1; flag_din = f;
        @(negedge clk); flag_wr = 1'b0;
    endtask

    task automatic op(input logic [2:0] d, input logic [2:0] s1, input logic [2:0] s2);
        @(negedge clk); op_valid = 1'b1; op_rd = d; op_rs1 = s1; op_rs2 = s2;
        @(negedge clk); op_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v, s, d, e, m;
        logic [7:0]  k;
        logic [3:0]  fl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        for (int i = 0; i < 8; i++) begin peek(3'(i), v); chk("R9 reg", v, 16'h0); end
        chk("R9 flags", {12'h0, flag_n, flag_z, flag_v, flag_c}, 16'h0);

        // R1 R2 R3 R4 R5 R6: all width/offset pairs under four data patterns
        for (int p = 0; p < 4; p++) begin
            for (int w = 0; w < 16; w++) begin
                for (int o = 0; o < 16; o++) begin
                    k = {4'(w), 4'(o)};
                    case (p)
                        0: begin s = 16'hFFFF; d = 16'h0000; end
                        1: begin s = 16'h0000; d = 16'h0000; end
                        default: begin s = rnd()[15:0]; d = rnd()[15:0]; end
                    endcase
                    fl = rnd()[3:0] | 4'b0010;
                    set_flags(fl);
                    load(3'd1, s);
                    load(3'd2, {rnd()[7:0], k});
                    load(3'd3, d);
                    op(3'd3, 3'd1, 3'd2);
                    peek(3'd3, v);
                    e = model(s, k, d);
                    m = fmask(k);
                    if (o + w > 15) chk("R3 clipped field", v & m, e & m);
                    else            chk("R1 field", v & m, e & m);
                    chk("R2 outside", v & ~m, d & ~m);
                    chk("R4 N", {15'h0, flag_n}, {15'h0, e[15]});
                    chk("R5 Z", {15'h0, flag_z}, {15'h0, e == 16'h0});
                    chk("R6 V", {15'h0, flag_v}, 16'h0);
                    chk("R6 C", {15'h0, flag_c}, {15'h0, fl[0]});
                end
            end
        end

        // R7: register 0 ignores loads, toggles as a source, drops op writes
        load(3'd0, 16'hFFFF);
        peek(3'd0, v); chk("R7 load r0", v, 16'h0);
        load(3'd4, 16'h1234);
        load(3'd2, 16'h0074);
        op(3'd4, 3'd0, 3'd2);
        peek(3'd4, v); chk("R7 toggle", v, 16'h1DC4);
        load(3'd1, 16'h00FF);
        load(3'd2, 16'h0070);
        op(3'd0, 3'd1, 3'd2);
        peek(3'd0, v); chk("R7 op to r0", v, 16'h0);
        chk("R7 flags from zero dst", {12'h0, flag_n, flag_z, flag_v, flag_c}, {12'h0, 1'b0, 1'b1, 1'b0, flag_c});

        // R8: strobes low, indices set, nothing moves
        load(3'd3, 16'hBEEF);
        set_flags(4'b1011);
        @(negedge clk); op_rd = 3'd3; op_rs1 = 3'd1; op_rs2 = 3'd2;
        @(negedge clk);
        peek(3'd3, v); chk("R8 reg idle", v, 16'hBEEF);
        chk("R8 flags idle", {12'h0, flag_n, flag_z, flag_v, flag_c}, 16'h000B);

        // R10: flag load, and loads lose to an operation
        set_flags(4'b0110);
        chk("R10 flag load", {12'h0, flag_n, flag_z, flag_v, flag_c}, 16'h0006);
        load(3'd5, 16'hAAAA);
        peek(3'd5, v); chk("R10 reg load", v, 16'hAAAA);
        load(3'd1, 16'h0000); load(3'd2, 16'h00F0); load(3'd3, 16'h0000);
        @(negedge clk); op_valid = 1'b1; op_rd = 3'd3; op_rs1 = 3'd1; op_rs2 = 3'd2;
        ld_valid = 1'b1; ld_idx = 3'd5; ld_data = 16'h5555; flag_wr = 1'b1; flag_din = 4'b0011;
        @(negedge clk); op_valid = 1'b0; ld_valid = 1'b0; flag_wr = 1'b0;
        peek(3'd5, v); chk("R10 load ignored", v, 16'hAAAA);
        peek(3'd3, v); chk("R10 op wins", v, 16'hFFFF);
        chk("R10 flag load ignored", {12'h0, flag_n, flag_z, flag_v, flag_c}, 16'h0008);

        // R9: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin peek(3'(i), v); chk("R9 rereset reg", v, 16'h0); end
        chk("R9 rereset flags", {12'h0, flag_n, flag_z, flag_v, flag_c}, 16'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule